// File: doc/BRIEF.md
# FP32 Reciprocal Estimate Unit

This unit returns a coarse approximation of 1/x for a single-precision floating-point operand. It is the kind of seed value that a vector reciprocal step refines later. It works in one fixed floating-point mode: denormal operands are flushed to zero, and any NaN produces the canonical quiet NaN. The mantissa of the result comes from an 8-bit index taken from the operand's fraction. A constant table maps that index to an 8-bit estimate with round-half-up accuracy. The exponent of the result is derived directly from the operand's exponent.

Operands arrive with a valid strobe. The result, a divide-by-zero flag and an underflow flag appear exactly one clock later, in registers. The flags describe only the operation presented in that cycle; they are not sticky. Special operands are recognised from their exponent and fraction codes. The checking order is NaN, then infinity, then zero or denormal, then an exponent too large to invert. Only operands that pass every check use the estimate table.

Top module: `rcp_est_top`

## Requirements
- R1: An operand with exponent field 255 and a non-zero fraction produces 0x7FC00000, whatever the operand's sign or payload, with both flags low.
- R2: An operand with exponent field 255 and a zero fraction produces a zero that carries the operand's sign (0x00000000 or 0x80000000), with both flags low.
- R3: An operand with exponent field 0, which covers both zeros and denormals, produces an infinity with the operand's sign (0x7F800000 or 0xFF800000) and raises out_dz.
- R4: An operand with exponent field 253 or 254 produces a zero with the operand's sign and raises out_uf.
- R5: For an exponent field e from 1 to 252, the result sign (bit 31) equals the operand sign and the result exponent field (bits 30:23) equals 253 − e, with both flags low.
- R6: For the same operands, let q = 256 + operand bits [22:15] and d = 2q+1. Let s = floor((524288 + d) / (2d)), a value in 256..511. Result bits [22:15] hold s[7:0] and result bits [14:0] are zero.
- R7: out_valid equals in_valid from one clock earlier. The result and flags for an operand appear one cycle after it is accepted, including when operands arrive on consecutive cycles.
- R8: out_dz and out_uf are never both high, and both are low whenever out_valid is low.
- R9: While in_valid is low, out_res keeps its previous value.
- R10: During and just after synchronous reset, out_valid, out_dz, out_uf and out_res are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_res | output | 32 | Single-precision reciprocal estimate |
| out_dz | output | 1 | Divide-by-zero for this result |
| out_uf | output | 1 | Underflow for this result |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- Signed NaNs with payloads: a unit that quiets and forwards the input NaN would leak the payload or the sign.
- Negative infinities and negative zeros: a unit that ignores the sign would return +0 or +inf for these.
- Denormals: a unit without flush-to-zero would compute a finite result and leave out_dz low.
- Exponents 252, 253 and 254: an off-by-one limit would either leak a result with exponent 0 or flag underflow one step too early.
- All 256 index values, checked against the round-half-up formula with both ends at 511 and 256: a wrong rounding step or a misplaced fraction slice shows up as a mantissa mismatch.
- Back-to-back operands and idle gaps: these expose any extra or missing pipeline stage, and any result that changes with no new operand.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  // Result exponent base: result exponent = BASE - operand exponent
  localparam int REXP_BASE = 2 * ((1 << (EXP_W - 1)) - 1) - 1;

  // Canonical quiet NaN pattern
  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [2:0] {
    CLS_NAN,
    CLS_INF,
    CLS_ZERO,
    CLS_UFLOW,
    CLS_NORM
  } rcp_class_e;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;

endpackage

// File: rtl/rcp_classify.sv
module rcp_classify
  import rcp_pkg::*;
#(
  parameter int E_W      = EXP_W,
  parameter int F_W      = FRAC_W,
  parameter int UF_LIMIT = REXP_BASE
) (
  input  logic [E_W-1:0] expo,
  input  logic [F_W-1:0] frac,
  output rcp_class_e     cls
);

  localparam logic [E_W-1:0] EXP_MAX = {E_W{1'b1}};
  localparam logic [E_W-1:0] EXP_UF  = E_W'(UF_LIMIT);

  // Priority: NaN, infinity, zero/denormal, large exponent, normal
  always_comb begin
    if (expo == EXP_MAX && frac != '0) begin
      cls = CLS_NAN;
    end else if (expo == EXP_MAX) begin
      cls = CLS_INF;
    end else if (expo == '0) begin
      cls = CLS_ZERO;
    end else if (expo >= EXP_UF) begin
      cls = CLS_UFLOW;
    end else begin
      cls = CLS_NORM;
    end
  end

endmodule

// File: rtl/rcp_est_kernel.sv
module rcp_est_kernel #(
  parameter int IDX_BITS = 8
) (
  input  logic [IDX_BITS-1:0] idx,
  output logic [IDX_BITS-1:0] est
);

  localparam int DEPTH = 1 << IDX_BITS;
  localparam int NUM   = 1 << (2 * IDX_BITS + 3);

  // s = floor(2^IDX * (2^(IDX+1) / (q + 0.5)) + 0.5), integer form
  function automatic int est_calc(input int q);
    int d;
    d = 2 * q + 1;
    return (NUM + d) / (2 * d);
  endfunction

  logic [IDX_BITS-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam int SVAL = est_calc(DEPTH + g);
    assign rom[g] = IDX_BITS'(SVAL);
  end

  assign est = rom[idx];

endmodule

// File: rtl/rcp_assemble.sv
module rcp_assemble
  import rcp_pkg::*;
#(
  parameter int IDX_BITS = 8
) (
  input  rcp_class_e          cls,
  input  logic                sign,
  input  logic [EXP_W-1:0]    expo,
  input  logic [IDX_BITS-1:0] est,
  output logic [WORD_W-1:0]   res,
  output logic                dz,
  output logic                uf
);

  localparam int PAD_W = FRAC_W - IDX_BITS;

  fp_word_t w;

  always_comb begin
    w  = '0;
    dz = 1'b0;
    uf = 1'b0;
    case (cls)
      CLS_NAN: begin
        w = QNAN_WORD;
      end
      CLS_INF: begin
        w.sign = sign;
      end
      CLS_ZERO: begin
        w.sign = sign;
        w.expo = '1;
        dz     = 1'b1;
      end
      CLS_UFLOW: begin
        w.sign = sign;
        uf     = 1'b1;
      end
      default: begin
        w.sign = sign;
        w.expo = EXP_W'(REXP_BASE) - expo;
        w.frac = {est, {PAD_W{1'b0}}};
      end
    endcase
  end

  assign res = w;

endmodule

// File: rtl/rcp_est_top.sv
module rcp_est_top
  import rcp_pkg::*;
#(
  parameter int IDX_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_op,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_res,
  output logic              out_dz,
  output logic              out_uf
);

  fp_word_t            op_w;
  rcp_class_e          cls_c;
  logic [IDX_BITS-1:0] est_c;
  logic [WORD_W-1:0]   res_c;
  logic                dz_c;
  logic                uf_c;

  assign op_w = in_op;

  rcp_classify #(
    .E_W      (EXP_W),
    .F_W      (FRAC_W),
    .UF_LIMIT (REXP_BASE)
  ) u_cls (
    .expo (op_w.expo),
    .frac (op_w.frac),
    .cls  (cls_c)
  );

  rcp_est_kernel #(
    .IDX_BITS (IDX_BITS)
  ) u_kern (
    .idx (op_w.frac[FRAC_W-1 -: IDX_BITS]),
    .est (est_c)
  );

  rcp_assemble #(
    .IDX_BITS (IDX_BITS)
  ) u_asm (
    .cls  (cls_c),
    .sign (op_w.sign),
    .expo (op_w.expo),
    .est  (est_c),
    .res  (res_c),
    .dz   (dz_c),
    .uf   (uf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_dz    <= 1'b0;
      out_uf    <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= in_valid;
      out_dz    <= in_valid & dz_c;
      out_uf    <= in_valid & uf_c;
      if (in_valid) begin
        out_res <= res_c;
      end
    end
  end

  AST_NAN_CANON: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[30:23] == 8'hFF && in_op[22:0] != '0)
      |=> (out_res == QNAN_WORD && !out_dz && !out_uf)); // R1

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[30:23] != 8'hFF)
      |=> (out_res[31] == $past(in_op[31]))); // R5

  AST_LOW_FRAC_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_res[14:0] == '0)); // R6

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R7

  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R7

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({out_dz, out_uf}) <= 1); // R8

  AST_FLAG_GATED: assert property (@(posedge clk) disable iff (rst)
    (out_dz || out_uf) |-> out_valid); // R8

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_res)); // R9

endmodule

// File: tb/rcp_est_top_tb_top.sv
module rcp_est_top_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_op;
  logic        out_valid;
  logic [31:0] out_res;
  logic        out_dz;
  logic        out_uf;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rcp_est_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_dz    (out_dz),
    .out_uf    (out_uf)
  );

  function automatic logic [7:0] exp_est(input logic [7:0] idx);
    int q;
    int d;
    int s;
    q = 256 + int'(idx);
    d = 2 * q + 1;
    s = (524288 + d) / (2 * d);
    return s[7:0];
  endfunction

  // Independent expectation written from the requirements
  task automatic model(input logic [31:0] op, output logic [31:0] r,
                       output logic dz, output logic uf);
    logic [7:0]  e;
    logic [22:0] f;
    e  = op[30:23];
    f  = op[22:0];
    dz = 1'b0;
    uf = 1'b0;
    if (e == 8'd255 && f != 0) begin
      r = 32'h7FC0_0000;
    end else if (e == 8'd255) begin
      r = {op[31], 31'd0};
    end else if (e == 8'd0) begin
      r  = {op[31], 8'hFF, 23'd0};
      dz = 1'b1;
    end else if (e >= 8'd253) begin
      r  = {op[31], 31'd0};
      uf = 1'b1;
    end else begin
      r = {op[31], 8'(253 - int'(e)), exp_est(f[22:15]), 15'd0};
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
    end
  endtask

  // One operand, checked one cycle later
  task automatic run_one(input string req, input logic [31:0] op);
    logic [31:0] r;
    logic dz;
    logic uf;
    model(op, r, dz, uf);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " res"}, out_res, r);
    chk({req, " flags/valid"}, {29'd0, out_valid, out_dz, out_uf},
        {29'd0, 1'b1, dz, uf});
  endtask

  task automatic t_reset();
    rst      = 1'b1;
    in_valid = 1'b0;
    in_op    = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {out_res[30:0], out_valid}, 32'd0);
    chk("R10 reset flags", {30'd0, out_dz, out_uf}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 after reset", {28'd0, out_valid, out_dz, out_uf, out_res[31]}, 32'd0);
  endtask

  task automatic t_nan();
    run_one("R1 qnan", 32'h7FC0_0000);
    run_one("R1 neg nan payload", 32'hFFC1_2345);
    run_one("R1 snan", 32'h7F80_0001);
  endtask

  task automatic t_inf();
    run_one("R2 +inf", 32'h7F80_0000);
    run_one("R2 -inf", 32'hFF80_0000);
  endtask

  task automatic t_zero();
    run_one("R3 +0", 32'h0000_0000);
    run_one("R3 -0", 32'h8000_0000);
    run_one("R3 -denormal", 32'h8000_0001);
    run_one("R3 +denormal", 32'h007F_FFFF);
  endtask

  task automatic t_uflow();
    run_one("R4 exp253", 32'h7E80_0000);
    run_one("R4 -exp254", 32'hFF7F_FFFF);
    run_one("R5 exp252 edge", 32'h7E00_0000);
    run_one("R5 min normal", 32'h0080_0000);
  endtask

  task automatic t_known();
    run_one("R6 one", 32'h3F80_0000);
    chk("R6 one literal", out_res, 32'h3F7F_8000);
    run_one("R6 one point five", 32'h3FC0_0000);
    chk("R6 1.5 literal", out_res, 32'h3F2A_8000);
    run_one("R5 minus four", 32'hC080_0000);
    chk("R5 -4 literal", out_res, 32'hBE7F_8000);
    run_one("R6 top index", 32'h3FFF_FFFF);
    chk("R6 top index literal", out_res, 32'h3F00_0000);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 256; i++) begin
      logic [31:0] op;
      op = {i[0], 8'(1 + (i * 7) % 252), i[7:0], 15'(i * 131)};
      run_one("R6 sweep", op);
    end
  endtask

  task automatic t_stream();
    logic [31:0] ra;
    logic [31:0] rb;
    logic dz;
    logic uf;
    model(32'h4040_0000, ra, dz, uf);
    model(32'h8000_0000, rb, dz, uf);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = 32'h4040_0000;
    @(negedge clk);
    in_op    = 32'h8000_0000;
    chk("R7 first of pair", out_res, ra);
    chk("R7 first flags", {29'd0, out_valid, out_dz, out_uf}, 32'd4);
    @(negedge clk);
    in_valid = 1'b0;
    in_op    = 32'h7E80_0000;
    chk("R7 second of pair", out_res, rb);
    chk("R7 second flags", {29'd0, out_valid, out_dz, out_uf}, 32'd6);
    @(negedge clk);
    chk("R8 idle flags", {29'd0, out_valid, out_dz, out_uf}, 32'd0);
    chk("R9 hold on idle", out_res, rb);
    in_op = 32'h3F80_0000;
    @(negedge clk);
    chk("R9 hold second idle", out_res, rb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_nan();
    t_inf();
    t_zero();
    t_uflow();
    t_known();
    t_sweep();
    t_stream();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule